// File: doc/BRIEF.md
# Pipelined Byte-Write Synchronous SRAM

This block is a synthesizable single-clock static RAM with registered inputs and a one-stage registered read path. On each rising edge it captures the address, the write data, three chip enables and the write controls. During the following cycle it decodes the captured controls into a per-lane write mask. That mask either updates the array or lets a read go ahead, and the read result lands in an output register at the next edge.

Writes are controlled in two ways. A global write strobe overrides everything and writes the whole word. Otherwise, a byte-write enable together with per-lane strobes picks any subset of the byte lanes. The shared data bus is split into a data-in port, a data-out port and an output-enable. The output-enable drops for write cycles and deselected cycles. It follows chip deselection after a single cycle, with no extra drain stage.

Top module: `sram_bytewr`

## Requirements
- R1: Address, data and all controls are captured at the rising edge. Back-to-back reads of different addresses each return the word for their own captured address, in issue order.
- R2: With gwN=0 in a selected cycle, all four lanes are written from dataIn, whatever bweN and bwN carry.
- R3: With gwN=1 and bweN=0 in a selected cycle, exactly the lanes i with bwN[i]=0 are written (lane i is bits 8i+7:8i). The other lanes keep their contents. With gwN=1 and bweN=1 the cycle is a read and nothing is written.
- R4: With gwN=1, bweN=0 and bwN=4'b1111, no lane is written and the cycle is handled as a read.
- R5: The chip is selected only when ce1N=0, ce2=1 and ce3N=0. Any other combination writes nothing and gives outEn=0 one cycle after capture.
- R6: A read captured at edge t drives dataOut with the stored word and sets outEn=1 after edge t+1.
- R7: A write cycle captured at edge t gives outEn=0 after edge t+1. A selected read directly after a deselected cycle drives the output again with no idle cycle between them (single-cycle deselect).
- R8: Whenever outEn=0, dataOut is all zeros.
- R9: A read of an address in the cycle right after a byte write to it returns the new bytes in the written lanes and the old bytes in the other lanes.
- R10: While rst_n=0, and before any access, outEn=0 and dataOut=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the control and pipeline registers |
| addrIn | input | ADDR_W | Word address |
| dataIn | input | LANES*LANE_W | Write data |
| gwN | input | 1 | Global write, active low |
| bweN | input | 1 | Byte-write enable, active low |
| bwN | input | LANES | Per-lane write strobes, active low |
| ce1N | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3N | input | 1 | Chip enable, active low |
| dataOut | output | LANES*LANE_W | Registered read data, zero when not driven |
| outEn | output | 1 | High when dataOut carries read data |

## Verification
The assertions check several rules on every cycle. The decoded lane mask must match the global-write, byte-write and chip-select rules from the captured inputs. A deselected or write cycle must be followed by a low output-enable two edges later. The output must read zero whenever it is not enabled, and a cycle may never be both a read and a write. Only the bench's scenarios can show the contents of the array. These include partial-lane merges, writes that were suppressed by deselection or an empty strobe set, read-after-write through the pipeline, and the order of back-to-back reads. The bench checks these against a reference memory model it keeps itself.

// File: rtl/sram_bytewr_pkg.sv
package sram_bytewr_pkg;

  // Strobes passed from the control decode to the datapath.
  typedef struct packed {
    logic sel;      // captured chip-enable combination selects the chip
    logic wrCycle;  // at least one lane is written this cycle
    logic rdCycle;  // selected cycle that writes nothing
  } ctrlStrb_t;

  // Chip select from the three enables of mixed polarity.
  function automatic logic chipSel(input logic ce1N, input logic ce2, input logic ce3N);
    return !ce1N && ce2 && !ce3N;
  endfunction

endpackage

// File: rtl/sram_bytewr_ctrl.sv
module sram_bytewr_ctrl
  import sram_bytewr_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gwN,
  input  logic             bweN,
  input  logic [LANES-1:0] bwN,
  input  logic             ce1N,
  input  logic             ce2,
  input  logic             ce3N,
  output ctrlStrb_t        strb,
  output logic [LANES-1:0] laneWe
);

  // Input capture registers, reset to the inactive level of each strobe.
  logic             gwNQ;
  logic             bweNQ;
  logic [LANES-1:0] bwNQ;
  logic             ce1NQ;
  logic             ce2Q;
  logic             ce3NQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gwNQ  <= 1'b1;
      bweNQ <= 1'b1;
      bwNQ  <= '1;
      ce1NQ <= 1'b1;
      ce2Q  <= 1'b0;
      ce3NQ <= 1'b1;
    end else begin
      gwNQ  <= gwN;
      bweNQ <= bweN;
      bwNQ  <= bwN;
      ce1NQ <= ce1N;
      ce2Q  <= ce2;
      ce3NQ <= ce3N;
    end
  end

  logic selQ;
  logic globalWr;
  logic byteWrEn;

  always_comb begin
    selQ     = chipSel(ce1NQ, ce2Q, ce3NQ);
    globalWr = !gwNQ;
    byteWrEn = !bweNQ;
  end

  // Per-lane write decode: the global write overrides the byte strobes.
  for (genvar i = 0; i < LANES; i++) begin : g_laneDec
    always_comb begin
      laneWe[i] = selQ && (globalWr || (byteWrEn && !bwNQ[i]));
    end
  end

  always_comb begin
    strb.sel     = selQ;
    strb.wrCycle = |laneWe;
    strb.rdCycle = selQ && !(|laneWe);
  end

  // R2: a selected global write enables every lane
  p_global_all_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    (!gwN && chipSel(ce1N, ce2, ce3N)) |=> (&laneWe));

  // R3: a byte write enables exactly the lanes whose strobes were low
  p_lane_mask_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    (gwN && !bweN && chipSel(ce1N, ce2, ce3N)) |=> (laneWe == ~$past(bwN)));

  // R5: an unselected cycle writes no lane
  p_no_sel_no_wr_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    !chipSel(ce1N, ce2, ce3N) |=> (laneWe == '0));

  // R4: byte-write enable with no strobes is a read
  p_empty_mask_rd_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    (gwN && !bweN && (&bwN) && chipSel(ce1N, ce2, ce3N)) |=> (strb.rdCycle && !strb.wrCycle));

endmodule

// File: rtl/sram_bytewr_dp.sv
module sram_bytewr_dp
  import sram_bytewr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addrIn,
  input  logic [LANES*LANE_W-1:0] dataIn,
  input  ctrlStrb_t               strb,
  input  logic [LANES-1:0]        laneWe,
  output logic [LANES*LANE_W-1:0] dataOut,
  output logic                    outEn
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DATA_W = LANES * LANE_W;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [DATA_W-1:0] rdWord;

  // Address and write-data capture registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrQ <= '0;
      dataQ <= '0;
    end else begin
      addrQ <= addrIn;
      dataQ <= dataIn;
    end
  end

  // One storage column per byte lane, each with its own write enable.
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] laneMem [DEPTH];

    always_ff @(posedge clk) begin
      if (laneWe[i]) begin
        laneMem[addrQ] <= dataQ[i*LANE_W +: LANE_W];
      end
    end

    always_comb begin
      rdWord[i*LANE_W +: LANE_W] = laneMem[addrQ];
    end
  end

  // Output stage: loaded on reads, cleared on writes and deselects.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outEn   <= 1'b0;
      dataOut <= '0;
    end else begin
      outEn   <= strb.rdCycle;
      dataOut <= strb.rdCycle ? rdWord : '0;
    end
  end

  // R8: the output reads zero whenever it is not enabled
  p_gated_out_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    !outEn |-> (dataOut == '0));

  // R7: a write cycle blanks the output at the next edge
  p_write_blank_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    strb.wrCycle |=> !outEn);

  // R6: a decoded read enables the output at the next edge
  p_read_drives_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    strb.rdCycle |=> outEn);

  // R7: a cycle is never both a read and a write
  p_rd_wr_excl_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.rdCycle, strb.wrCycle}));

endmodule

// File: rtl/sram_bytewr.sv
module sram_bytewr
  import sram_bytewr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addrIn,
  input  logic [LANES*LANE_W-1:0] dataIn,
  input  logic                    gwN,
  input  logic                    bweN,
  input  logic [LANES-1:0]        bwN,
  input  logic                    ce1N,
  input  logic                    ce2,
  input  logic                    ce3N,
  output logic [LANES*LANE_W-1:0] dataOut,
  output logic                    outEn
);

  ctrlStrb_t        strb;
  logic [LANES-1:0] laneWe;

  sram_bytewr_ctrl #(
    .LANES (LANES)
  ) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .gwN    (gwN),
    .bweN   (bweN),
    .bwN    (bwN),
    .ce1N   (ce1N),
    .ce2    (ce2),
    .ce3N   (ce3N),
    .strb   (strb),
    .laneWe (laneWe)
  );

  sram_bytewr_dp #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES),
    .LANE_W (LANE_W)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .addrIn  (addrIn),
    .dataIn  (dataIn),
    .strb    (strb),
    .laneWe  (laneWe),
    .dataOut (dataOut),
    .outEn   (outEn)
  );

  // R5: deselected inputs leave the output disabled two edges later
  p_deselect_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    !chipSel(ce1N, ce2, ce3N) |-> ##2 !outEn);

  // R7: a selected global write leaves the output disabled two edges later
  p_gw_blank_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    (!gwN && chipSel(ce1N, ce2, ce3N)) |-> ##2 !outEn);

endmodule

// File: tb/sim_sram_bytewr.sv
`timescale 1ns/1ps
module sim_sram_bytewr;

  localparam int ADDR_W = 6;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int DW     = LANES * LANE_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [ADDR_W-1:0] addrIn;
  logic [DW-1:0]     dataIn;
  logic              gwN, bweN;
  logic [LANES-1:0]  bwN;
  logic              ce1N, ce2, ce3N;
  logic [DW-1:0]     dataOut;
  logic              outEn;

  always #2 clk = ~clk;  // 250 MHz

  sram_bytewr #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u0 (
    .clk(clk), .rst_n(rst_n), .addrIn(addrIn), .dataIn(dataIn),
    .gwN(gwN), .bweN(bweN), .bwN(bwN), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
    .dataOut(dataOut), .outEn(outEn)
  );

  typedef struct {
    int          due;
    logic        en;
    logic [DW-1:0] data;
    string       tag;
  } exp_t;

  exp_t          sb[$];
  logic [DW-1:0] model [1 << ADDR_W];
  int            cyc = 0;
  int            checks = 0;
  int            errors = 0;
  bit            done = 0;

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // Monitor: pops expected items as their cycle arrives.
  always @(posedge clk) begin
    #1;
    cyc++;
    while (sb.size() > 0 && sb[0].due == cyc) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (outEn !== e.en) begin
        errors++;
        $display("FAIL %s outEn actual=%0b expected=%0b", e.tag, outEn, e.en);
      end
      checks++;
      if (dataOut !== e.data) begin
        errors++;
        $display("FAIL %s dataOut actual=%h expected=%h", e.tag, dataOut, e.data);
      end
    end
  end

  // Driver: one access per cycle; ce is {ce1N, ce2, ce3N}, select = 3'b010.
  task automatic access(input logic [ADDR_W-1:0] a, input logic [DW-1:0] d,
                        input logic gw, input logic bwe, input logic [LANES-1:0] bw,
                        input logic [2:0] ce, input string tag);
    logic sel;
    logic [LANES-1:0] mask;
    exp_t e;
    @(negedge clk);
    addrIn = a; dataIn = d; gwN = gw; bweN = bwe; bwN = bw;
    {ce1N, ce2, ce3N} = ce;
    sel = (ce == 3'b010);
    for (int i = 0; i < LANES; i++)
      mask[i] = sel && (!gw || (!bwe && !bw[i]));
    for (int i = 0; i < LANES; i++)
      if (mask[i]) model[a][i*LANE_W +: LANE_W] = d[i*LANE_W +: LANE_W];
    e.due  = cyc + 2;
    e.en   = sel && (mask == '0);
    e.data = e.en ? model[a] : '0;
    e.tag  = tag;
    sb.push_back(e);
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input string tag);
    access(a, 32'hDEAD_BEEF, 1'b1, 1'b1, 4'b0000, 3'b010, tag);
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      report();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < (1 << ADDR_W); i++) model[i] = '0;
    rst_n = 1'b0;
    addrIn = '0; dataIn = '0; gwN = 1'b1; bweN = 1'b1; bwN = '1;
    ce1N = 1'b1; ce2 = 1'b0; ce3N = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (outEn !== 1'b0 || dataOut !== '0) begin
      errors++;
      $display("FAIL R10 reset actual=%0b/%h expected=0/0", outEn, dataOut);
    end
    rst_n = 1'b1;

    // Clear the locations used so the model matches the array.
    for (int i = 0; i < 16; i++)
      access(i[ADDR_W-1:0], '0, 1'b0, 1'b1, 4'b1111, 3'b010, "R2 init");

    // R2: global write overrides random byte controls.
    for (int i = 0; i < 8; i++)
      access(i[ADDR_W-1:0], 32'h1111_1111 * (i + 1), 1'b0, i[0], i[3:0] ^ 4'b0101,
             3'b010, "R2 global write");
    for (int i = 0; i < 8; i++) rd(i[ADDR_W-1:0], "R6 read latency");

    // R3/R9: byte writes each followed at once by a read.
    access(6'd3, 32'hAABB_CCDD, 1'b1, 1'b0, 4'b1010, 3'b010, "R3 lanes 0,2");
    rd(6'd3, "R9 read after byte write");
    access(6'd4, 32'h0102_0304, 1'b1, 1'b0, 4'b0111, 3'b010, "R3 lane 3");
    rd(6'd4, "R9 read after lane 3 write");
    access(6'd5, 32'hF0F0_F0F0, 1'b1, 1'b0, 4'b1110, 3'b010, "R3 lane 0");
    rd(6'd5, "R9 read after lane 0 write");
    // R3: byte-write enable high means no write.
    access(6'd3, 32'h5555_5555, 1'b1, 1'b1, 4'b0000, 3'b010, "R3 bwe off is read");
    rd(6'd3, "R3 unchanged after bwe off");
    // R4: no strobes is a read.
    access(6'd4, 32'h7777_7777, 1'b1, 1'b0, 4'b1111, 3'b010, "R4 empty strobes read");
    rd(6'd4, "R4 unchanged");

    // R5: every non-selecting enable combination blocks a global write.
    for (int c = 0; c < 8; c++) begin
      if (c != 2) begin
        access(6'd9, 32'h9999_0000 + c, 1'b0, 1'b0, 4'b0000, c[2:0], "R5 deselect write");
        rd(6'd9, "R5 no write when deselected");
      end
    end

    // R7: single-cycle deselect between reads, and write blanking.
    rd(6'd1, "R7 read before deselect");
    access(6'd2, '0, 1'b1, 1'b1, 4'b1111, 3'b110, "R7 deselect");
    rd(6'd2, "R7 read right after deselect");
    access(6'd10, 32'hCAFE_0010, 1'b0, 1'b1, 4'b1111, 3'b010, "R7 write blanks output");
    rd(6'd10, "R7 read after write");

    // R1: alternating back-to-back reads keep their order.
    for (int i = 0; i < 6; i++) rd(i[0] ? 6'd3 : 6'd10, "R1 back-to-back reads");
    // R8: deselected cycle outputs zero.
    access(6'd3, '0, 1'b1, 1'b1, 4'b1111, 3'b111, "R8 zero when disabled");

    repeat (5) @(negedge clk);
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R6 pending results actual=%0d expected=0", sb.size());
    end
    done = 1;
    report();
    $finish;
  end

endmodule